// File: doc/BRIEF.md
# Two-Beat Burst SRAM with Same-Cycle Write Forwarding

This block is a synthesizable behavioural model of a static memory with a separate write path and read path. A read command and a write command can both be taken in the same clock cycle. Each command moves a burst of two words, beat 0 first and then beat 1. Write data enters on its own input bus, one beat per cycle: beat 0 in the command cycle and beat 1 in the following cycle. Each beat carries active-high byte enables. Read data leaves on a separate output bus, two beats on consecutive cycles, after a fixed latency that is set by a parameter. A valid strobe marks each beat.

A read returns the contents as they stand after every write whose command cycle came before it. One case needs special handling: a read and a write can name the same address in the same cycle. The read then returns the burst that is arriving with that write, not the older stored words. The byte enables still apply, so a byte whose enable is off comes from the array. The array is held in registers and clears to zero on reset. Double-rate pin timing and echo clocks are outside the model, so each beat takes one clock.

Top module: `burst2_sram`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rd_valid` is 0, `rd_data` is 0 and every array word reads as zero. Whenever `rd_valid` is 0, `rd_data` is 0.
- R2: A read taken at clock edge t puts beat 0 on `rd_data` with `rd_valid`=1 after edge t+RD_LAT, and beat 1 after edge t+RD_LAT+1. `rd_valid` is 0 in every other cycle.
- R3: A write taken at edge t captures beat 0 from `wr_data`/`wr_be` at edge t and beat 1 at edge t+1. Bit i of `wr_be` enables bits [8i+7:8i] of that beat.
- R4: A byte whose enable bit is 0 keeps its earlier stored value.
- R5: A read returns, for each beat, the stored word as updated by every accepted write with an earlier command cycle.
- R6: When a read and a write are taken in the same cycle with equal addresses and all byte enables set, both read beats equal the incoming write beats.
- R7: In the same-cycle matching case, bytes whose enable is 0 come from the array and bytes whose enable is 1 come from the incoming beat.
- R8: A read and a write taken in the same cycle to different addresses both complete. The read returns the earlier contents of its own address, and the write lands.
- R9: A write command in the cycle right after an accepted write is ignored. Its address is not written, and the data on `wr_data` in that cycle acts only as beat 1 of the earlier burst.
- R10: A read command in the cycle right after an accepted read is ignored and produces no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read command request |
| rd_addr | input | ADDR_W | Read burst address |
| wr_en | input | 1 | Write command request |
| wr_addr | input | ADDR_W | Write burst address |
| wr_data | input | DATA_W | Write beat data (beat 0 in command cycle, beat 1 next) |
| wr_be | input | DATA_W/8 | Active-high byte enables for the current write beat |
| rd_valid | output | 1 | Read beat valid strobe |
| rd_data | output | DATA_W | Read beat data, zero when not valid |

## Verification
The assertions watch the following on every cycle. Accepted writes and accepted reads are each spaced at least two cycles apart. A first read beat is always followed by a second. A fully masked beat leaves its stored word unchanged. A forwarded read word matches what the array holds one edge later. Other properties need whole scenarios, and only the bench can show them. These are the exact latency, ordering against earlier writes, pass-through under mixed byte enables, and the absence of side effects from ignored commands and from noise on the write bus while `wr_en` is low. The bench checks these by comparing every read beat against a reference memory that it keeps itself.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
    // bits per byte lane governed by one write enable bit
    localparam int BYTE_W = 8;
    // words moved by every command
    localparam int BEATS  = 2;
endpackage

// File: rtl/burst2_store.sv
module burst2_store
    import burst2_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wd0,
    input  logic [DATA_W/BYTE_W-1:0]   wbe0,
    input  logic [DATA_W-1:0]          wd1,
    input  logic [DATA_W/BYTE_W-1:0]   wbe1,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [DATA_W-1:0]          rd0,
    output logic [DATA_W-1:0]          rd1
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BE_W  = DATA_W / BYTE_W;

    logic [DATA_W-1:0] mem_q [DEPTH][BEATS];
    logic [DATA_W-1:0] mem_d [DEPTH][BEATS];
    logic [DATA_W-1:0] nw0, nw1;
    logic              hit;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int i = 0; i < BE_W; i++) begin
            if (be[i]) r[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    // write-through read: a burst completing this edge at the read address
    // is visible to the read in the same cycle
    always_comb begin
        nw0   = lane_merge(mem_q[waddr][0], wd0, wbe0);
        nw1   = lane_merge(mem_q[waddr][1], wd1, wbe1);
        hit   = we && (waddr == raddr);
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr][0] = nw0;
            mem_d[waddr][1] = nw1;
        end
        rd0 = hit ? nw0 : mem_q[raddr][0];
        rd1 = hit ? nw1 : mem_q[raddr][1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wbe0 == '0) |=> mem_q[$past(waddr)][0] == $past(mem_q[waddr][0])); // R4

    AST_FWD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == raddr) |=> (mem_q[$past(raddr)][0] == $past(rd0)
                                 && mem_q[$past(raddr)][1] == $past(rd1))); // R6
endmodule

// File: rtl/burst2_rd_pipe.sv
module burst2_rd_pipe #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_w0,
    input  logic [DATA_W-1:0] in_w1,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_w0,
    output logic [DATA_W-1:0] out_w1
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign out_valid = in_valid;
            assign out_w0    = in_w0;
            assign out_w1    = in_w1;
        end else begin : g_reg
            typedef struct packed {
                logic              v;
                logic [DATA_W-1:0] w0;
                logic [DATA_W-1:0] w1;
            } stage_t;

            stage_t st_q [DEPTH];
            stage_t st_d [DEPTH];

            always_comb begin
                st_d[0] = '{v: in_valid, w0: in_w0, w1: in_w1};
                for (int i = 1; i < DEPTH; i++) st_d[i] = st_q[i-1];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '{default: '0};
                else        st_q <= st_d;
            end

            assign out_valid = st_q[DEPTH-1].v;
            assign out_w0    = st_q[DEPTH-1].w0;
            assign out_w1    = st_q[DEPTH-1].w1;
        end
    endgenerate
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
    import burst2_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int RD_LAT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/BYTE_W-1:0] wr_be,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int BE_W   = DATA_W / BYTE_W;
    localparam int PIPE_D = RD_LAT - 1;

    typedef struct packed {
        logic              wr_pend;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wd0;
        logic [BE_W-1:0]   wbe0;
        logic              rd_pend;
        logic [ADDR_W-1:0] rd_addr;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
        logic              hold_valid;
        logic [DATA_W-1:0] hold_data;
    } state_t;

    state_t            s_q, s_d;
    logic              wr_acc, rd_acc;
    logic [DATA_W-1:0] arr_w0, arr_w1;
    logic              pv;
    logic [DATA_W-1:0] p0, p1;

    burst2_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (s_q.wr_pend),
        .waddr (s_q.wr_addr),
        .wd0   (s_q.wd0),
        .wbe0  (s_q.wbe0),
        .wd1   (wr_data),
        .wbe1  (wr_be),
        .raddr (s_q.rd_addr),
        .rd0   (arr_w0),
        .rd1   (arr_w1)
    );

    burst2_rd_pipe #(.DATA_W(DATA_W), .DEPTH(PIPE_D)) pipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_q.rd_pend),
        .in_w0     (arr_w0),
        .in_w1     (arr_w1),
        .out_valid (pv),
        .out_w0    (p0),
        .out_w1    (p1)
    );

    always_comb begin
        s_d    = s_q;
        wr_acc = wr_en && !s_q.wr_pend;
        rd_acc = rd_en && !s_q.rd_pend;

        // write command: hold beat 0 until beat 1 arrives
        s_d.wr_pend = wr_acc;
        if (wr_acc) begin
            s_d.wr_addr = wr_addr;
            s_d.wd0     = wr_data;
            s_d.wbe0    = wr_be;
        end

        // read command: array sampled one cycle later
        s_d.rd_pend = rd_acc;
        if (rd_acc) s_d.rd_addr = rd_addr;

        // serialise the two beats
        if (pv) begin
            s_d.out_valid  = 1'b1;
            s_d.out_data   = p0;
            s_d.hold_valid = 1'b1;
            s_d.hold_data  = p1;
        end else if (s_q.hold_valid) begin
            s_d.out_valid  = 1'b1;
            s_d.out_data   = s_q.hold_data;
            s_d.hold_valid = 1'b0;
        end else begin
            s_d.out_valid  = 1'b0;
            s_d.out_data   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = s_q.out_valid;
    assign rd_data  = s_q.out_data;

    AST_WR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wr_pend |=> !s_q.wr_pend); // R9

    AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rd_pend |=> !s_q.rd_pend); // R10

    AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.out_valid && s_q.hold_valid) |=> rd_valid); // R2
endmodule

// File: tb/burst2_sram_tb.sv
module burst2_sram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int BW  = DW / 8;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [BW-1:0] wr_be = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    burst2_sram #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int            n_cmp = 0, n_bad = 0, edge_n = 0;
    logic [DW-1:0] ref_mem [2**AW][2];
    bit            exp_v [16];
    logic [DW-1:0] exp_d [16];
    string         exp_t [16];
    bit            wbusy = 0, rbusy = 0, pb_v = 0;
    logic [DW-1:0] pb_d;
    logic [BW-1:0] pb_be;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                            input logic [BW-1:0] b);
        logic [DW-1:0] r = o;
        for (int i = 0; i < BW; i++) if (b[i]) r[i*8 +: 8] = n[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s at edge %0d: actual %h expected %h", tag, edge_n, act, expv);
        end
    endtask

    task automatic sample();
        int s = edge_n % 16;
        if (exp_v[s]) begin
            chk({exp_t[s], " valid"}, DW'(rd_valid), DW'(1));
            chk({exp_t[s], " data"}, rd_data, exp_d[s]);
            exp_v[s] = 0;
        end else begin
            chk("R2,R10 idle valid", DW'(rd_valid), '0);
            chk("R1 idle data", rd_data, '0);
        end
    endtask

    task automatic step(input bit rq, input logic [AW-1:0] ra, input bit wq, input logic [AW-1:0] wa,
                        input logic [DW-1:0] d0, input logic [BW-1:0] b0,
                        input logic [DW-1:0] d1, input logic [BW-1:0] b1, input string tag);
        bit wacc = wq && !wbusy;
        bit racc = rq && !rbusy;
        int s;
        rd_en = rq; rd_addr = ra; wr_en = wq; wr_addr = wa;
        if (pb_v)    begin wr_data = pb_d; wr_be = pb_be; end
        else if (wq) begin wr_data = d0;   wr_be = b0;    end
        else         begin wr_data = DW'($urandom); wr_be = BW'($urandom); end
        if (wacc) begin
            ref_mem[wa][0] = merge(ref_mem[wa][0], d0, b0);
            ref_mem[wa][1] = merge(ref_mem[wa][1], d1, b1);
        end
        pb_v = wacc; pb_d = d1; pb_be = b1;
        wbusy = wacc; rbusy = racc;
        if (racc) begin
            s = (edge_n + 1 + LAT) % 16;
            exp_v[s] = 1; exp_d[s] = ref_mem[ra][0]; exp_t[s] = {tag, " beat0"};
            s = (edge_n + 2 + LAT) % 16;
            exp_v[s] = 1; exp_d[s] = ref_mem[ra][1]; exp_t[s] = {tag, " beat1"};
        end
        @(posedge clk);
        edge_n++;
        @(negedge clk);
        sample();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, '0, '0, '0, '0, "idle");
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < 2**AW; a++) begin ref_mem[a][0] = '0; ref_mem[a][1] = '0; end
        for (int i = 0; i < 16; i++) exp_v[i] = 0;

        repeat (3) @(negedge clk);
        chk("R1 reset valid", DW'(rd_valid), '0);
        chk("R1 reset data", rd_data, '0);
        rst_n = 1'b1;

        // R1: unwritten address reads zero
        step(1, 4'd5, 0, '0, '0, '0, '0, '0, "R1");
        idle(LAT + 3);
        // R3 / R5: full burst, read afterwards
        step(0, '0, 1, 4'd2, 16'h1111, 2'b11, 16'h2222, 2'b11, "R3");
        idle(1);
        step(1, 4'd2, 0, '0, '0, '0, '0, '0, "R5");
        idle(LAT + 3);
        // R4: partial byte enables on each beat
        step(0, '0, 1, 4'd2, 16'hAAAA, 2'b01, 16'hBBBB, 2'b10, "R4");
        idle(1);
        step(1, 4'd2, 0, '0, '0, '0, '0, '0, "R4");
        idle(LAT + 3);
        // R6: same cycle, same address, all bytes
        step(1, 4'd3, 1, 4'd3, 16'h3C3C, 2'b11, 16'h4D4D, 2'b11, "R6");
        idle(LAT + 3);
        // R7: same cycle, same address, mixed enables
        step(1, 4'd3, 1, 4'd3, 16'h5E5E, 2'b10, 16'h6F6F, 2'b01, "R7");
        idle(LAT + 3);
        // R8: same cycle, different addresses
        step(1, 4'd2, 1, 4'd3, 16'h7070, 2'b11, 16'h8181, 2'b11, "R8");
        idle(1);
        step(1, 4'd3, 0, '0, '0, '0, '0, '0, "R8");
        idle(LAT + 3);
        // R9: second write right after the first is ignored
        step(0, '0, 1, 4'd6, 16'h6060, 2'b11, 16'h6161, 2'b11, "R9");
        step(0, '0, 1, 4'd7, 16'hDEAD, 2'b11, 16'hBEEF, 2'b11, "R9");
        idle(2);
        step(1, 4'd7, 0, '0, '0, '0, '0, '0, "R9");
        idle(1);
        step(1, 4'd6, 0, '0, '0, '0, '0, '0, "R9");
        idle(LAT + 3);
        // R10: second read right after the first is ignored
        step(1, 4'd2, 0, '0, '0, '0, '0, '0, "R10");
        step(1, 4'd6, 0, '0, '0, '0, '0, '0, "R10");
        idle(LAT + 4);

        // constrained random mix over a narrow address range
        for (int k = 0; k < 600; k++) begin
            step(bit'($urandom % 2), AW'($urandom % 4), bit'($urandom % 2), AW'($urandom % 4),
                 DW'($urandom), BW'($urandom), DW'($urandom), BW'($urandom), "R5,R6,R7");
        end
        idle(LAT + 4);
        finish_run();
    end
endmodule